// File: doc/BRIEF.md
# Split-Region Memory Permission Checker

This block guards one on-chip SRAM address window. Every access presented to it (an address, a kind and a valid strobe) is judged against programmed permissions in the same cycle. The block returns an allow flag and, for a valid access that is refused, a violation pulse. The bottom of the window is made of a fixed number of equal-sized blocks, each with its own write/read/execute triplet. The remainder of the window is one region cut in two by a movable word-aligned split address, and each side of the cut carries its own triplet.

Configuration is written through a small register port with a select code. A lock register makes the permissions and the split address read-only until the next reset. Addresses outside the window pass unchecked.

Top module: `perm_check`

## Requirements
- R1: With default parameters the fixed part is four 8 KiB blocks starting at byte 0x4002_0000. Block i takes its triplet from bits [3i+2:3i] of the block-permission register (select 1, write data bits [11:0]).
- R2: Inside a triplet, bit 0 is execute, bit 1 is read and bit 2 is write. Kind code 0 (fetch) needs bit 0, code 1 (data read) needs bit 1 and code 2 (data write) needs bit 2. Kind code 3 is refused anywhere inside the window.
- R3: The split region runs from the end of the last block (0x4002_8000) up to the window end (0x4007_0000, exclusive). An address whose word address is below the split value uses the low triplet, written from data bits [19:17]. Any other address in the region uses the high triplet, written from data bits [22:20]. Both are written with select 2.
- R4: The split value is a 17-bit word address taken from data bits [16:0] on a select-2 write. It is compared with address bits [18:2], so the two lowest address bits never move an access across the split.
- R5: A split value below the minimum word address 0xC000 (byte 0x4003_0000) is stored as 0xC000.
- R6: An access whose address is below 0x4002_0000 or at or above 0x4007_0000 is allowed and never raises a violation, whatever its kind.
- R7: acc_allow depends combinationally on the present address, kind and configuration. acc_viol is high in the same cycle exactly when acc_valid is high and acc_allow is low.
- R8: A configuration write is captured at the rising clock edge while cfg_we is high. Checks made in that cycle still use the previous configuration.
- R9: A select-0 write with data bit 0 set locks the block. While locked, writes with any select are ignored, so permissions, split value and the lock itself stay unchanged until reset.
- R10: After reset every triplet is zero, the split value is 0xC000 and the lock is clear. Writes with select 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lock, 1 block permissions, 2 split, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 reserved |
| acc_addr | input | 32 | Byte address of the access |
| acc_allow | output | 1 | Access permitted |
| acc_viol | output | 1 | Valid access refused this cycle |

## Verification
The allow and violation outputs are combinational, so their result is due in the same cycle as the stimulus. The bench drives each access at the falling edge and samples the outputs one nanosecond later. A configuration write only becomes visible after the next rising edge. To keep to that, the bench checks an access while the write strobe is still high and expects the old configuration, and it updates its reference model only after that edge. Every later check, including those that probe locked or reserved writes, is made at least one falling edge after the write.

// File: rtl/pmc_pkg.sv
// Package: shared types for the split-region permission checker.
// Assumes the permission triplet layout {write, read, execute}, MSB first.
package pmc_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_LOCK  = 2'd0,
        SEL_BLK   = 2'd1,
        SEL_SPLIT = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
    } perm_t;

    // Does triplet p grant an access of kind k
    function automatic logic perm_grants(perm_t p, acc_kind_e k);
        logic g;
        case (k)
            ACC_FETCH: g = p.x;
            ACC_READ:  g = p.r;
            ACC_WRITE: g = p.w;
            default:   g = 1'b0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pmc_cfg_regs.sv
// Configuration store: per-block triplets, split word address, side triplets
// and the sticky lock. Assumes writes arrive one per cycle on a single port;
// the split value is clamped to SPLIT_MIN on capture.
module pmc_cfg_regs
    import pmc_pkg::*;
#(
    parameter int              NUM_BLK   = 4,
    parameter int              SPLIT_W   = 17,
    parameter logic [SPLIT_W-1:0] SPLIT_MIN = 17'h0C000,
    parameter int              DATA_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [3*NUM_BLK-1:0]   blk_perm_q,
    output logic [SPLIT_W-1:0]     split_q,
    output perm_t                  lo_perm_q,
    output perm_t                  hi_perm_q,
    output logic                   lock_q
);

    localparam int PERM_BITS = 3 * NUM_BLK;
    localparam int LO_LSB    = SPLIT_W;
    localparam int HI_LSB    = SPLIT_W + 3;
    localparam int USED_BITS = SPLIT_W + 6;

    logic [SPLIT_W-1:0] split_in;
    logic               unused_wdata;

    assign unused_wdata = ^cfg_wdata[DATA_W-1:USED_BITS];

    // Clamp the requested split word address to the legal floor
    always_comb begin
        split_in = cfg_wdata[SPLIT_W-1:0];
        if (split_in < SPLIT_MIN) begin
            split_in = SPLIT_MIN;
        end
    end

    // Register capture, blocked entirely once the lock is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_perm_q <= '0;
            split_q    <= SPLIT_MIN;
            lo_perm_q  <= '0;
            hi_perm_q  <= '0;
            lock_q     <= 1'b0;
        end else if (cfg_we && !lock_q) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_LOCK: begin
                    if (cfg_wdata[0]) begin
                        lock_q <= 1'b1;
                    end
                end
                SEL_BLK: begin
                    blk_perm_q <= cfg_wdata[PERM_BITS-1:0];
                end
                SEL_SPLIT: begin
                    split_q   <= split_in;
                    lo_perm_q <= perm_t'(cfg_wdata[LO_LSB+2:LO_LSB]);
                    hi_perm_q <= perm_t'(cfg_wdata[HI_LSB+2:HI_LSB]);
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/pmc_region_decode.sv
// Address decoder: finds whether an address is in the window, which fixed
// block it hits, or on which side of the split it falls. Assumes the whole
// split region shares address bits above SPLIT_W+1.
module pmc_region_decode #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4002_0000,
    parameter logic [ADDR_W-1:0] WIN_END   = 32'h4007_0000,
    parameter int                BLK_BYTES = 8192,
    parameter int                NUM_BLK   = 4,
    parameter int                SPLIT_W   = 17,
    parameter int                IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SPLIT_W-1:0] split_q,
    output logic               in_window,
    output logic               in_block,
    output logic [IDX_W-1:0]   blk_idx,
    output logic               split_low
);

    logic [NUM_BLK-1:0] hit;

    // One range comparator per fixed block
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        localparam logic [ADDR_W-1:0] LO = WIN_BASE + ADDR_W'(i * BLK_BYTES);
        localparam logic [ADDR_W-1:0] HI = WIN_BASE + ADDR_W'((i + 1) * BLK_BYTES);
        assign hit[i] = (addr >= LO) && (addr < HI);
    end

    // Window membership
    assign in_window = (addr >= WIN_BASE) && (addr < WIN_END);
    assign in_block  = |hit;

    // Encode the one-hot block hit into an index
    always_comb begin
        blk_idx = '0;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (hit[i]) begin
                blk_idx = IDX_W'(i);
            end
        end
    end

    // Split side from the word-address bits only
    assign split_low = addr[SPLIT_W+1:2] < split_q;

endmodule

// File: rtl/perm_check.sv
// Top: split-region memory permission checker. Combines the configuration
// store and the address decoder and judges each access in the same cycle.
// Assumes one access per cycle and a synchronous active-low reset.
module perm_check
    import pmc_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4002_0000,
    parameter logic [ADDR_W-1:0] WIN_END   = 32'h4007_0000,
    parameter int                BLK_BYTES = 8192,
    parameter int                NUM_BLK   = 4,
    parameter int                SPLIT_W   = 17,
    parameter int                MIN_GAP   = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_allow,
    output logic              acc_viol
);

    localparam int                PERM_BITS   = 3 * NUM_BLK;
    localparam int                IDX_W       = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam logic [ADDR_W-1:0] SPLIT_MIN_B = WIN_BASE + ADDR_W'(NUM_BLK * BLK_BYTES + MIN_GAP);
    localparam logic [SPLIT_W-1:0] SPLIT_MIN_W = SPLIT_MIN_B[SPLIT_W+1:2];

    logic [PERM_BITS-1:0] blk_perm_q;
    logic [SPLIT_W-1:0]   split_q;
    perm_t                lo_perm_q;
    perm_t                hi_perm_q;
    logic                 lock_q;
    logic                 in_window;
    logic                 in_block;
    logic [IDX_W-1:0]     blk_idx;
    logic                 split_low;
    perm_t                sel_perm;

    pmc_cfg_regs #(
        .NUM_BLK   (NUM_BLK),
        .SPLIT_W   (SPLIT_W),
        .SPLIT_MIN (SPLIT_MIN_W),
        .DATA_W    (32)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .blk_perm_q (blk_perm_q),
        .split_q    (split_q),
        .lo_perm_q  (lo_perm_q),
        .hi_perm_q  (hi_perm_q),
        .lock_q     (lock_q)
    );

    pmc_region_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_END   (WIN_END),
        .BLK_BYTES (BLK_BYTES),
        .NUM_BLK   (NUM_BLK),
        .SPLIT_W   (SPLIT_W),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr      (acc_addr),
        .split_q   (split_q),
        .in_window (in_window),
        .in_block  (in_block),
        .blk_idx   (blk_idx),
        .split_low (split_low)
    );

    // Pick the triplet that governs the addressed location
    always_comb begin
        if (in_block) begin
            sel_perm = perm_t'(blk_perm_q[3*blk_idx +: 3]);
        end else if (split_low) begin
            sel_perm = lo_perm_q;
        end else begin
            sel_perm = hi_perm_q;
        end
    end

    // Verdict: outside the window passes, inside needs the matching bit
    assign acc_allow = !in_window || perm_grants(sel_perm, acc_kind_e'(acc_kind));
    assign acc_viol  = acc_valid && !acc_allow;

endmodule

// File: rtl/pmc_checker.sv
// Assertion checker for perm_check, attached by bind. Watches the ports and
// the configuration state; assumes synchronous active-low reset.
module pmc_checker #(
    parameter int                 SPLIT_W   = 17,
    parameter int                 PERM_BITS = 12,
    parameter logic [SPLIT_W-1:0] SPLIT_MIN = 17'h0C000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [1:0]           cfg_sel,
    input logic [PERM_BITS-1:0] blk_wdata,
    input logic                 acc_valid,
    input logic [1:0]           acc_kind,
    input logic                 acc_allow,
    input logic                 acc_viol,
    input logic                 in_window,
    input logic                 lock_q,
    input logic [PERM_BITS-1:0] blk_perm_q,
    input logic [SPLIT_W-1:0]   split_q,
    input logic [2:0]           lo_perm_q,
    input logic [2:0]           hi_perm_q
);

    // R6: outside the window nothing is refused
    p_outside_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |-> (acc_allow && !acc_viol));

    // R2: reserved kind never passes inside the window
    p_rsvd_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && acc_kind == 2'd3) |-> !acc_allow);

    // R7: a violation only accompanies a valid access
    p_viol_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_viol |-> acc_valid);

    // R5: stored split never drops under the floor
    p_split_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        split_q >= SPLIT_MIN);

    // R9: lock is sticky
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R9: configuration frozen while locked
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(blk_perm_q) && $stable(split_q)
                    && $stable(lo_perm_q) && $stable(hi_perm_q)));

    // R8: an unlocked block-permission write lands one edge later
    p_blk_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1 && !lock_q) |=> blk_perm_q == $past(blk_wdata));

endmodule

bind perm_check pmc_checker #(
    .SPLIT_W   (SPLIT_W),
    .PERM_BITS (PERM_BITS),
    .SPLIT_MIN (SPLIT_MIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .blk_wdata  (cfg_wdata[PERM_BITS-1:0]),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .acc_allow  (acc_allow),
    .acc_viol   (acc_viol),
    .in_window  (in_window),
    .lock_q     (lock_q),
    .blk_perm_q (blk_perm_q),
    .split_q    (split_q),
    .lo_perm_q  (lo_perm_q),
    .hi_perm_q  (hi_perm_q)
);

// File: tb/tb_perm_check.sv
module tb_perm_check;

    localparam logic [31:0] BASE   = 32'h4002_0000;
    localparam logic [31:0] SPLB   = 32'h4002_8000;
    localparam logic [31:0] WEND   = 32'h4007_0000;
    localparam logic [16:0] MIN_W  = 17'h0C000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_addr = '0;
    logic        acc_allow;
    logic        acc_viol;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model of the configuration
    logic [11:0] m_blk = '0;
    logic [16:0] m_split = MIN_W;
    logic [2:0]  m_lo = '0;
    logic [2:0]  m_hi = '0;
    logic        m_lock = 1'b0;

    always #4 clk = ~clk;

    perm_check dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_allow(acc_allow), .acc_viol(acc_viol)
    );

    function automatic logic exp_allow(logic [31:0] a, logic [1:0] k);
        logic [2:0] p;
        if (a < BASE || a >= WEND) return 1'b1;
        if (k == 2'd3) return 1'b0;
        if (a < SPLB) p = m_blk[3*((a - BASE) >> 13) +: 3];
        else if (a[18:2] < m_split) p = m_lo;
        else p = m_hi;
        return p[k];
    endfunction

    task automatic compare(string tag);
        logic ea, ev;
        ea = exp_allow(acc_addr, acc_kind);
        ev = acc_valid && !ea;
        n_chk++;
        if (acc_allow !== ea || acc_viol !== ev) begin
            n_fail++;
            $display("FAIL %s addr=%h kind=%0d allow=%b exp=%b viol=%b exp=%b",
                     tag, acc_addr, acc_kind, acc_allow, ea, acc_viol, ev);
        end
    endtask

    task automatic acc(logic [31:0] a, logic [1:0] k, logic v, string tag);
        @(negedge clk);
        acc_addr = a; acc_kind = k; acc_valid = v;
        #1 compare(tag);
    endtask

    task automatic model_write(logic [1:0] s, logic [31:0] d);
        if (m_lock) return;
        case (s)
            2'd0: if (d[0]) m_lock = 1'b1;
            2'd1: m_blk = d[11:0];
            2'd2: begin
                m_split = (d[16:0] < MIN_W) ? MIN_W : d[16:0];
                m_lo = d[19:17];
                m_hi = d[22:20];
            end
            default: ;
        endcase
    endtask

    // write, checking that the old configuration still applies in the write cycle (R8)
    task automatic cfg_write(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        acc_addr = BASE; acc_kind = 2'd1; acc_valid = 1'b1;
        #1 compare("R8 old config in write cycle");
        @(posedge clk);
        model_write(s, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] split_word(logic [16:0] w, logic [2:0] lo, logic [2:0] hi);
        return {9'd0, hi, lo, w};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        acc(BASE, 2'd1, 1'b1, "R10 reset block0 read denied");
        acc(32'h4006_FFFC, 2'd2, 1'b1, "R10 reset split high write denied");
        acc(32'h4002_9000, 2'd0, 1'b1, "R10 reset split low fetch denied");
        // R6: outside window
        acc(32'h4001_FFFC, 2'd3, 1'b1, "R6 below window");
        acc(WEND, 2'd1, 1'b1, "R6 at window end");
        acc(32'hFFFF_FFFC, 2'd2, 1'b1, "R6 top of space");

        // R1 / R2: per-block triplets b0=111 b1=001 b2=010 b3=100
        cfg_write(2'd1, {20'd0, 3'b100, 3'b010, 3'b001, 3'b111});
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 4; k++) begin
                acc(BASE + b*8192 + 32'h100, k[1:0], 1'b1, "R1 R2 block kind");
            end
        end
        acc(32'h4002_1FFC, 2'd1, 1'b1, "R1 last word block0");
        acc(32'h4002_2000, 2'd1, 1'b1, "R1 first word block1");
        acc(32'h4002_7FFF, 2'd2, 1'b1, "R1 last byte block3");
        acc(32'h4002_0010, 2'd3, 1'b1, "R2 reserved kind in full-perm block");
        acc(32'h4002_2010, 2'd1, 1'b0, "R7 refused but not valid");

        // R3 / R4: split at word 0x10000 (byte 0x4004_0000), low=011, high=100
        cfg_write(2'd2, split_word(17'h10000, 3'b011, 3'b100));
        acc(32'h4002_8000, 2'd1, 1'b1, "R3 region start low read");
        acc(32'h4003_FFFC, 2'd1, 1'b1, "R3 word below split low read");
        acc(32'h4003_FFFF, 2'd2, 1'b1, "R4 byte below split low write");
        acc(32'h4004_0000, 2'd1, 1'b1, "R3 at split high read");
        acc(32'h4004_0000, 2'd2, 1'b1, "R3 at split high write");
        acc(32'h4004_0003, 2'd0, 1'b1, "R4 low bits high fetch");
        acc(32'h4006_FFFF, 2'd2, 1'b1, "R3 region end high write");

        // R5: split below floor clamps to 0x4003_0000
        cfg_write(2'd2, split_word(17'h00100, 3'b010, 3'b001));
        acc(32'h4002_FFFC, 2'd1, 1'b1, "R5 clamp below floor low");
        acc(32'h4003_0000, 2'd1, 1'b1, "R5 clamp floor high read");
        acc(32'h4003_0000, 2'd0, 1'b1, "R5 clamp floor high fetch");

        // R10: select 3 changes nothing
        cfg_write(2'd3, 32'hFFFF_FFFF);
        acc(32'h4003_0000, 2'd0, 1'b1, "R10 sel3 ignored high");
        acc(32'h4002_2000, 2'd1, 1'b1, "R10 sel3 ignored block1");

        // R1..R8 random configurations and accesses
        for (int round = 0; round < 15; round++) begin
            logic [16:0] sw;
            sw = ($urandom % 4 == 0) ? 17'($urandom % 32'hC000)
                                     : 17'(32'hC000 + $urandom % 32'h10001);
            cfg_write(2'd1, $urandom);
            cfg_write(2'd2, split_word(sw, 3'($urandom), 3'($urandom)));
            for (int n = 0; n < 120; n++) begin
                logic [31:0] a;
                case ($urandom % 8)
                    0: a = BASE - 32'd1 - ($urandom % 4096);
                    1: a = WEND + ($urandom % 4096);
                    2, 3: a = BASE + ($urandom % 32768);
                    4, 5: a = SPLB + ($urandom % 32'h48000);
                    default: a = ({13'h0800, m_split, 2'b00} - 32'd16) + ($urandom % 32);
                endcase
                acc(a, 2'($urandom), 1'($urandom), "R3 R7 random");
            end
        end

        // R9: lock freezes everything
        cfg_write(2'd1, {20'd0, 12'b100_010_001_111});
        cfg_write(2'd2, split_word(17'h10000, 3'b011, 3'b100));
        cfg_write(2'd0, 32'd1);
        cfg_write(2'd1, 32'd0);
        acc(BASE, 2'd2, 1'b1, "R9 locked block write ignored");
        cfg_write(2'd2, split_word(17'h1B000, 3'b000, 3'b000));
        acc(32'h4004_0000, 2'd2, 1'b1, "R9 locked split ignored high");
        acc(32'h4003_FFFC, 2'd1, 1'b1, "R9 locked split ignored low");
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd0);
        acc(32'h4002_2000, 2'd0, 1'b1, "R9 lock not clearable");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule